// File: doc/BRIEF.md
# Thermal Sensor Port Control and Status

This block is the command and status register front end of a thermal video sensor port whose pixel data arrives as SPI segments. Software writes 32-bit command words; each word is decoded into persistent control levels for the segment receiver, the frame output path, the sensor's reset, power-down and master-clock pins, the SPI clock mode and four general-purpose pins. Almost every stored control has a companion "set" bit, and a field changes only when its companion bit is 1. The SPI enable field and each GPIO field instead use a 2-bit code in which 0 means leave unchanged.

In the other direction the block assembles a 32-bit read-only status word. It combines the id of the last segment received, the GPIO pin levels, the receiver and output busy flags, a sticky CRC error flag, a program-detect pin and a 6-bit sequence number. The sequence number is captured whenever a status read is requested, so software can pair each status word with its request. The segment receiver and frame buffer sit outside the block: it only drives their enables and samples their status.

Top module: `thermal_port_ctrl`

## Requirements
- R1: Command bits [1:0] are the receiver code, applied on a command write: 0 leaves rxEnable and rxReset unchanged; 1 sets rxReset=1 and rxEnable=0; 2 sets rxReset=0 and rxEnable=0; 3 sets rxReset=0 and rxEnable=1.
- R2: acceptSeg0 takes command bit 2 only when command bit 3 is 1. Otherwise it keeps its value.
- R3: outEnable takes command bit 4 only when bit 5 is 1. Command bit 6 raises singleFrame for exactly the one cycle after that command edge. singleFrame is not stored.
- R4: Status bit 10 is a sticky CRC error flag. It is set by a one-cycle rxCrcErr pulse and cleared by a command with bit 7 = 1. When both happen in the same cycle, the flag is set.
- R5: Four level/set pairs take effect only when their set bit is 1: sensorResetN at bits 8/9, powerDownN at 10/11, mclkEnable at 12/13, spiClkContinuous at 14/15. The two active-low outputs assert when 0 is written.
- R6: spiClkEn is 1 when spiClkContinuous is 1 or spiCsActive is 1, and 0 otherwise.
- R7: Bits [23:16] hold one 2-bit code per GPIO, with GPIO0 in bits [17:16]. Code 0 leaves the pin unchanged, 1 drives low, 2 drives high, and 3 releases the pin to input. gpioOut equals the inverse of code bit 0, and gpioOe is 1 unless the code is 3.
- R8: The status word holds the following fields: [3:0] the segment id latched on rxSegDone; [7:4] gpioIn; bit 8 rxInBusy; bit 9 rxOutBusy; bit 10 the CRC flag; bit 24 pgmDetect; bit 25 rxInBusy OR rxOutBusy; [31:26] the sequence number. All other bits are 0.
- R9: After synchronous reset, sensorResetN and powerDownN are 0, while mclkEnable, rxEnable, outEnable, acceptSeg0, spiClkContinuous, singleFrame, every gpioOe and the CRC flag are all 0. rxReset is 1.
- R10: Command bits 24 to 31 have no effect on any output.
- R11: On a cycle with statusReq high, seqIn is captured and appears in status bits [31:26] from the next cycle on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cmdValid | input | 1 | Command write strobe |
| cmdData | input | 32 | Command word |
| statusReq | input | 1 | Status read request, captures seqIn |
| seqIn | input | 6 | Sequence number to capture |
| rxSegDone | input | 1 | Segment finished pulse from the receiver |
| rxSegId | input | 4 | Id of the finished segment |
| rxInBusy | input | 1 | Receiver waiting for or taking in a segment |
| rxOutBusy | input | 1 | Frame transfer to memory in progress |
| rxCrcErr | input | 1 | One-cycle CRC error pulse |
| spiCsActive | input | 1 | SPI chip select is active |
| gpioIn | input | 4 | GPIO pin levels |
| pgmDetect | input | 1 | Program-detect pin level |
| rxEnable | output | 1 | Receiver enable |
| rxReset | output | 1 | Receiver reset |
| acceptSeg0 | output | 1 | Accept segment 0 in place of the expected one |
| outEnable | output | 1 | Frame output to memory enable |
| singleFrame | output | 1 | Single-frame output request pulse |
| sensorResetN | output | 1 | Sensor reset, active low |
| powerDownN | output | 1 | Sensor power-down, active low |
| mclkEnable | output | 1 | Sensor master clock enable |
| spiClkContinuous | output | 1 | Free-running SPI clock selected |
| spiClkEn | output | 1 | SPI clock gate enable |
| gpioOut | output | 4 | GPIO output data |
| gpioOe | output | 4 | GPIO output enables |
| statusWord | output | 32 | Assembled status word |

## Verification
The hardest case to reach is a receiver CRC error pulse that lands on the same edge as a flag-clear command, because the ordering between the two only shows when they coincide exactly. The stimulus first reaches this case with a directed command that carries the clear bit while rxCrcErr is held for that one cycle. The random phase then draws both independently, so they coincide many more times. The "no change" paths are covered by commands whose set bits or codes are zero. Their effect is checked through the full output vector after each write.

// File: rtl/thermal_port_pkg.sv
package thermal_port_pkg;

  parameter int CMD_W    = 32;
  parameter int GPIO_N   = 4;
  parameter int SEG_ID_W = 4;
  parameter int SEQ_W    = 6;
  parameter int STAT_W   = 32;

  // command field positions (software-visible layout)
  localparam int SPI_LSB     = 0;
  localparam int SEG0_BIT    = 2;
  localparam int OUT_BIT     = 4;
  localparam int SINGLE_BIT  = 6;
  localparam int CRC_CLR_BIT = 7;
  localparam int RST_BIT     = 8;
  localparam int PWDN_BIT    = 10;
  localparam int MCLK_BIT    = 12;
  localparam int SCLK_BIT    = 14;
  localparam int GPIO_LSB    = 16;

  // status field positions
  localparam int ST_GPIO_LSB = SEG_ID_W;
  localparam int ST_INBUSY   = 8;
  localparam int ST_OUTBUSY  = 9;
  localparam int ST_CRC      = 10;
  localparam int ST_PGM      = 24;
  localparam int ST_BUSY     = 25;
  localparam int ST_SEQ_LSB  = STAT_W - SEQ_W;

  typedef enum logic [1:0] {
    SPI_NOP     = 2'd0,
    SPI_RST_OFF = 2'd1,
    SPI_RUN_OFF = 2'd2,
    SPI_RUN_ON  = 2'd3
  } spiCode_e;

  typedef enum logic [1:0] {
    GPIO_NOP  = 2'd0,
    GPIO_LOW  = 2'd1,
    GPIO_HIGH = 2'd2,
    GPIO_IN   = 2'd3
  } gpioCode_e;

  typedef struct packed {
    logic              ldSpi;
    logic              spiRstVal;
    logic              spiEnVal;
    logic              ldSeg0;
    logic              seg0Val;
    logic              ldOut;
    logic              outVal;
    logic              single;
    logic              crcClr;
    logic              ldRst;
    logic              rstVal;
    logic              ldPwdn;
    logic              pwdnVal;
    logic              ldMclk;
    logic              mclkVal;
    logic              ldSclk;
    logic              sclkVal;
    logic [GPIO_N-1:0] ldGpio;
    logic [GPIO_N-1:0] gpioDrv;
    logic [GPIO_N-1:0] gpioOeVal;
  } ctrlStrobes_t;

endpackage

// File: rtl/thermal_cmd_decode.sv
module thermal_cmd_decode
  import thermal_port_pkg::*;
(
  input  logic             cmdValid,
  input  logic [CMD_W-1:0] cmdData,
  output ctrlStrobes_t     strb
);

  localparam int USED_W = GPIO_LSB + 2 * GPIO_N;

  logic [USED_W-1:0] cmdUsed;
  spiCode_e          spiCode;

  assign cmdUsed = cmdData[USED_W-1:0];
  assign spiCode = spiCode_e'(cmdUsed[SPI_LSB +: 2]);

  always_comb begin
    strb.ldSpi     = cmdValid && (spiCode != SPI_NOP);
    strb.spiRstVal = (spiCode == SPI_RST_OFF);
    strb.spiEnVal  = (spiCode == SPI_RUN_ON);
    strb.ldSeg0    = cmdValid && cmdUsed[SEG0_BIT + 1];
    strb.seg0Val   = cmdUsed[SEG0_BIT];
    strb.ldOut     = cmdValid && cmdUsed[OUT_BIT + 1];
    strb.outVal    = cmdUsed[OUT_BIT];
    strb.single    = cmdValid && cmdUsed[SINGLE_BIT];
    strb.crcClr    = cmdValid && cmdUsed[CRC_CLR_BIT];
    strb.ldRst     = cmdValid && cmdUsed[RST_BIT + 1];
    strb.rstVal    = cmdUsed[RST_BIT];
    strb.ldPwdn    = cmdValid && cmdUsed[PWDN_BIT + 1];
    strb.pwdnVal   = cmdUsed[PWDN_BIT];
    strb.ldMclk    = cmdValid && cmdUsed[MCLK_BIT + 1];
    strb.mclkVal   = cmdUsed[MCLK_BIT];
    strb.ldSclk    = cmdValid && cmdUsed[SCLK_BIT + 1];
    strb.sclkVal   = cmdUsed[SCLK_BIT];
  end

  for (genvar g = 0; g < GPIO_N; g++) begin : gGpioDec
    gpioCode_e code;
    assign code              = gpioCode_e'(cmdUsed[GPIO_LSB + 2*g +: 2]);
    assign strb.ldGpio[g]    = cmdValid && (code != GPIO_NOP);
    assign strb.gpioDrv[g]   = ~code[0];
    assign strb.gpioOeVal[g] = (code != GPIO_IN);
  end

endmodule

// File: rtl/thermal_port_regs.sv
module thermal_port_regs
  import thermal_port_pkg::*;
(
  input  logic                clk,
  input  logic                rst,
  input  ctrlStrobes_t        strb,
  input  logic                statusReq,
  input  logic [SEQ_W-1:0]    seqIn,
  input  logic                rxSegDone,
  input  logic [SEG_ID_W-1:0] rxSegId,
  input  logic                rxInBusy,
  input  logic                rxOutBusy,
  input  logic                rxCrcErr,
  input  logic                spiCsActive,
  input  logic [GPIO_N-1:0]   gpioIn,
  input  logic                pgmDetect,
  output logic                rxEnable,
  output logic                rxReset,
  output logic                acceptSeg0,
  output logic                outEnable,
  output logic                singleFrame,
  output logic                sensorResetN,
  output logic                powerDownN,
  output logic                mclkEnable,
  output logic                spiClkContinuous,
  output logic                spiClkEn,
  output logic [GPIO_N-1:0]   gpioOut,
  output logic [GPIO_N-1:0]   gpioOe,
  output logic [STAT_W-1:0]   statusWord
);

  logic                crcSticky;
  logic [SEG_ID_W-1:0] segIdR;
  logic [SEQ_W-1:0]    seqR;

  always_ff @(posedge clk) begin
    if (rst) begin
      rxEnable         <= 1'b0;
      rxReset          <= 1'b1;
      acceptSeg0       <= 1'b0;
      outEnable        <= 1'b0;
      singleFrame      <= 1'b0;
      sensorResetN     <= 1'b0;
      powerDownN       <= 1'b0;
      mclkEnable       <= 1'b0;
      spiClkContinuous <= 1'b0;
    end else begin
      if (strb.ldSpi) begin
        rxEnable <= strb.spiEnVal;
        rxReset  <= strb.spiRstVal;
      end
      if (strb.ldSeg0) acceptSeg0       <= strb.seg0Val;
      if (strb.ldOut)  outEnable        <= strb.outVal;
      if (strb.ldRst)  sensorResetN     <= strb.rstVal;
      if (strb.ldPwdn) powerDownN       <= strb.pwdnVal;
      if (strb.ldMclk) mclkEnable       <= strb.mclkVal;
      if (strb.ldSclk) spiClkContinuous <= strb.sclkVal;
      singleFrame <= strb.single;
    end
  end

  for (genvar g = 0; g < GPIO_N; g++) begin : gGpioReg
    always_ff @(posedge clk) begin
      if (rst) begin
        gpioOut[g] <= 1'b0;
        gpioOe[g]  <= 1'b0;
      end else if (strb.ldGpio[g]) begin
        gpioOut[g] <= strb.gpioDrv[g];
        gpioOe[g]  <= strb.gpioOeVal[g];
      end
    end
  end

  // sticky CRC flag: a new error outranks a clear in the same cycle
  always_ff @(posedge clk) begin
    if (rst)              crcSticky <= 1'b0;
    else if (rxCrcErr)    crcSticky <= 1'b1;
    else if (strb.crcClr) crcSticky <= 1'b0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      segIdR <= '0;
      seqR   <= '0;
    end else begin
      if (rxSegDone) segIdR <= rxSegId;
      if (statusReq) seqR   <= seqIn;
    end
  end

  assign spiClkEn = spiClkContinuous | spiCsActive;

  always_comb begin
    statusWord                             = '0;
    statusWord[SEG_ID_W-1:0]               = segIdR;
    statusWord[ST_GPIO_LSB +: GPIO_N]      = gpioIn;
    statusWord[ST_INBUSY]                  = rxInBusy;
    statusWord[ST_OUTBUSY]                 = rxOutBusy;
    statusWord[ST_CRC]                     = crcSticky;
    statusWord[ST_PGM]                     = pgmDetect;
    statusWord[ST_BUSY]                    = rxInBusy | rxOutBusy;
    statusWord[ST_SEQ_LSB +: SEQ_W]        = seqR;
  end

endmodule

// File: rtl/thermal_port_ctrl.sv
module thermal_port_ctrl
  import thermal_port_pkg::*;
(
  input  logic                clk,
  input  logic                rst,
  input  logic                cmdValid,
  input  logic [CMD_W-1:0]    cmdData,
  input  logic                statusReq,
  input  logic [SEQ_W-1:0]    seqIn,
  input  logic                rxSegDone,
  input  logic [SEG_ID_W-1:0] rxSegId,
  input  logic                rxInBusy,
  input  logic                rxOutBusy,
  input  logic                rxCrcErr,
  input  logic                spiCsActive,
  input  logic [GPIO_N-1:0]   gpioIn,
  input  logic                pgmDetect,
  output logic                rxEnable,
  output logic                rxReset,
  output logic                acceptSeg0,
  output logic                outEnable,
  output logic                singleFrame,
  output logic                sensorResetN,
  output logic                powerDownN,
  output logic                mclkEnable,
  output logic                spiClkContinuous,
  output logic                spiClkEn,
  output logic [GPIO_N-1:0]   gpioOut,
  output logic [GPIO_N-1:0]   gpioOe,
  output logic [STAT_W-1:0]   statusWord
);

  ctrlStrobes_t strb;

  thermal_cmd_decode decode_i (
    .cmdValid (cmdValid),
    .cmdData  (cmdData),
    .strb     (strb)
  );

  thermal_port_regs regs_i (
    .clk              (clk),
    .rst              (rst),
    .strb             (strb),
    .statusReq        (statusReq),
    .seqIn            (seqIn),
    .rxSegDone        (rxSegDone),
    .rxSegId          (rxSegId),
    .rxInBusy         (rxInBusy),
    .rxOutBusy        (rxOutBusy),
    .rxCrcErr         (rxCrcErr),
    .spiCsActive      (spiCsActive),
    .gpioIn           (gpioIn),
    .pgmDetect        (pgmDetect),
    .rxEnable         (rxEnable),
    .rxReset          (rxReset),
    .acceptSeg0       (acceptSeg0),
    .outEnable        (outEnable),
    .singleFrame      (singleFrame),
    .sensorResetN     (sensorResetN),
    .powerDownN       (powerDownN),
    .mclkEnable       (mclkEnable),
    .spiClkContinuous (spiClkContinuous),
    .spiClkEn         (spiClkEn),
    .gpioOut          (gpioOut),
    .gpioOe           (gpioOe),
    .statusWord       (statusWord)
  );

endmodule

// File: rtl/thermal_port_checker.sv
module thermal_port_checker
  import thermal_port_pkg::*;
(
  input logic                clk,
  input logic                rst,
  input logic                cmdValid,
  input logic [CMD_W-1:0]    cmdData,
  input logic                rxCrcErr,
  input logic                spiCsActive,
  input logic                rxEnable,
  input logic                rxReset,
  input logic                acceptSeg0,
  input logic                singleFrame,
  input logic                spiClkContinuous,
  input logic                spiClkEn,
  input logic [GPIO_N-1:0]   gpioOe,
  input logic [STAT_W-1:0]   statusWord
);

  AST_SPI_RESET_OFF: assert property (@(posedge clk) disable iff (rst)
    cmdValid && cmdData[1:0] == 2'd1 |=> rxReset && !rxEnable); // R1

  AST_SEG0_HOLD: assert property (@(posedge clk) disable iff (rst)
    !(cmdValid && cmdData[SEG0_BIT+1]) |=> $stable(acceptSeg0)); // R2

  AST_SINGLE_FROM_CMD: assert property (@(posedge clk) disable iff (rst)
    !(cmdValid && cmdData[SINGLE_BIT]) |=> !singleFrame); // R3

  AST_CRC_SET_WINS: assert property (@(posedge clk) disable iff (rst)
    rxCrcErr |=> statusWord[ST_CRC]); // R4

  AST_SPICLK_GATED: assert property (@(posedge clk) disable iff (rst)
    !spiClkContinuous && !spiCsActive |-> !spiClkEn); // R6

  AST_GPIO0_RELEASE: assert property (@(posedge clk) disable iff (rst)
    cmdValid && cmdData[GPIO_LSB +: 2] == 2'd3 |=> !gpioOe[0]); // R7

endmodule

bind thermal_port_ctrl thermal_port_checker checker_i (
  .clk              (clk),
  .rst              (rst),
  .cmdValid         (cmdValid),
  .cmdData          (cmdData),
  .rxCrcErr         (rxCrcErr),
  .spiCsActive      (spiCsActive),
  .rxEnable         (rxEnable),
  .rxReset          (rxReset),
  .acceptSeg0       (acceptSeg0),
  .singleFrame      (singleFrame),
  .spiClkContinuous (spiClkContinuous),
  .spiClkEn         (spiClkEn),
  .gpioOe           (gpioOe),
  .statusWord       (statusWord)
);

// File: tb/thermal_port_ctrl_tb.sv
module thermal_port_ctrl_tb_top;

  localparam int CLK_PER = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cmdValid = 1'b0;
  logic [31:0] cmdData = '0;
  logic        statusReq = 1'b0;
  logic [5:0]  seqIn = '0;
  logic        rxSegDone = 1'b0;
  logic [3:0]  rxSegId = '0;
  logic        rxInBusy = 1'b0;
  logic        rxOutBusy = 1'b0;
  logic        rxCrcErr = 1'b0;
  logic        spiCsActive = 1'b0;
  logic [3:0]  gpioIn = '0;
  logic        pgmDetect = 1'b0;

  logic        rxEnable, rxReset, acceptSeg0, outEnable, singleFrame;
  logic        sensorResetN, powerDownN, mclkEnable, spiClkContinuous, spiClkEn;
  logic [3:0]  gpioOut, gpioOe;
  logic [31:0] statusWord;

  int checks = 0;
  int fails  = 0;

  // expected model state, packed as
  // {en, rst, seg0, out, rstN, pwdnN, mclk, sclk, gpioOut[3:0], gpioOe[3:0]}
  logic [15:0] mCtrl;
  logic        mCrc;
  logic [3:0]  mSeg;
  logic [5:0]  mSeq;

  always #(CLK_PER/2) clk = ~clk;

  thermal_port_ctrl dut_i (
    .clk(clk), .rst(rst), .cmdValid(cmdValid), .cmdData(cmdData),
    .statusReq(statusReq), .seqIn(seqIn), .rxSegDone(rxSegDone),
    .rxSegId(rxSegId), .rxInBusy(rxInBusy), .rxOutBusy(rxOutBusy),
    .rxCrcErr(rxCrcErr), .spiCsActive(spiCsActive), .gpioIn(gpioIn),
    .pgmDetect(pgmDetect), .rxEnable(rxEnable), .rxReset(rxReset),
    .acceptSeg0(acceptSeg0), .outEnable(outEnable), .singleFrame(singleFrame),
    .sensorResetN(sensorResetN), .powerDownN(powerDownN),
    .mclkEnable(mclkEnable), .spiClkContinuous(spiClkContinuous),
    .spiClkEn(spiClkEn), .gpioOut(gpioOut), .gpioOe(gpioOe),
    .statusWord(statusWord)
  );

  localparam logic [15:0] RESET_CTRL = 16'b0100_0000_0000_0000;

  function automatic logic [15:0] nextCtrl(logic [15:0] cur, logic [31:0] d);
    logic [15:0] n = cur;
    case (d[1:0])
      2'd1: n[15:14] = 2'b01;
      2'd2: n[15:14] = 2'b00;
      2'd3: n[15:14] = 2'b10;
      default: ;
    endcase
    if (d[3])  n[13] = d[2];
    if (d[5])  n[12] = d[4];
    if (d[9])  n[11] = d[8];
    if (d[11]) n[10] = d[10];
    if (d[13]) n[9]  = d[12];
    if (d[15]) n[8]  = d[14];
    for (int g = 0; g < 4; g++) begin
      logic [1:0] c = d[16 + 2*g +: 2];
      if (c != 2'd0) begin
        n[4 + g] = ~c[0];
        n[g]     = (c != 2'd3);
      end
    end
    return n;
  endfunction

  function automatic logic [31:0] expStatus();
    logic [31:0] s = '0;
    s[3:0]   = mSeg;
    s[7:4]   = gpioIn;
    s[8]     = rxInBusy;
    s[9]     = rxOutBusy;
    s[10]    = mCrc;
    s[24]    = pgmDetect;
    s[25]    = rxInBusy | rxOutBusy;
    s[31:26] = mSeq;
    return s;
  endfunction

  function automatic logic [15:0] dutCtrl();
    return {rxEnable, rxReset, acceptSeg0, outEnable, sensorResetN, powerDownN,
            mclkEnable, spiClkContinuous, gpioOut, gpioOe};
  endfunction

  task automatic check(string req, logic [31:0] got, logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  // one command cycle; outputs checked at the following negedge
  task automatic doCmd(string req, logic [31:0] d, logic crcPulse);
    @(negedge clk);
    cmdValid = 1'b1;
    cmdData  = d;
    rxCrcErr = crcPulse;
    @(negedge clk);
    cmdValid = 1'b0;
    rxCrcErr = 1'b0;
    mCtrl = nextCtrl(mCtrl, d);
    if (crcPulse) mCrc = 1'b1;
    else if (d[7]) mCrc = 1'b0;
    check(req, {16'd0, dutCtrl()}, {16'd0, mCtrl});
    check(req, {31'd0, singleFrame}, {31'd0, d[6]});
    check(req, statusWord, expStatus());
  endtask

  initial begin
    #(CLK_PER * 150000);
    fails++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    mCtrl = RESET_CTRL; mCrc = 0; mSeg = 0; mSeq = 0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R9 reset state
    check("R9", {16'd0, dutCtrl()}, {16'd0, RESET_CTRL});
    check("R9", {31'd0, singleFrame}, 32'd0);
    check("R9", statusWord, expStatus());

    // R1 receiver codes
    doCmd("R1", 32'h3, 0);
    doCmd("R1", 32'h0, 0);
    doCmd("R1", 32'h2, 0);
    doCmd("R1", 32'h1, 0);
    // R2 seg0 pair
    doCmd("R2", 32'h4, 0);
    doCmd("R2", 32'hC, 0);
    doCmd("R2", 32'h8, 0);
    // R3 output enable and single pulse
    doCmd("R3", 32'h30, 0);
    doCmd("R3", 32'h40, 0);
    @(negedge clk);
    check("R3", {31'd0, singleFrame}, 32'd0);
    // R5 level/set pairs
    doCmd("R5", 32'h5500, 0);
    doCmd("R5", 32'hFF00, 0);
    doCmd("R5", 32'hAA00, 0);
    // R7 gpio codes
    doCmd("R7", 32'h00E4_0000, 0);
    doCmd("R7", 32'h0000_0000, 0);
    doCmd("R7", 32'h00FF_0000, 0);
    doCmd("R7", 32'h00AA_0000, 0);
    // R10 high bits ignored
    doCmd("R10", 32'hFF00_0000, 0);
    // R4 sticky CRC
    doCmd("R4", 32'h0, 1);
    doCmd("R4", 32'h0, 0);
    doCmd("R4", 32'h80, 0);
    doCmd("R4", 32'h80, 1);
    doCmd("R4", 32'h80, 0);

    // R6 spi clock gating
    for (int m = 0; m < 4; m++) begin
      doCmd("R6", m[1] ? 32'hC000 : 32'h8000, 0);
      spiCsActive = m[0];
      #1;
      check("R6", {31'd0, spiClkEn}, {31'd0, m[1] | m[0]});
    end
    spiCsActive = 0;

    // R8 status fields and R11 sequence capture
    @(negedge clk);
    rxSegDone = 1; rxSegId = 4'd3; statusReq = 1; seqIn = 6'h2D;
    gpioIn = 4'hA; rxInBusy = 1; pgmDetect = 1;
    @(negedge clk);
    rxSegDone = 0; statusReq = 0; seqIn = 6'h11;
    mSeg = 4'd3; mSeq = 6'h2D;
    check("R8", statusWord, expStatus());
    check("R11", {26'd0, statusWord[31:26]}, {26'd0, 6'h2D});
    rxInBusy = 0; rxOutBusy = 1; rxSegId = 4'd0;
    @(negedge clk);
    check("R8", statusWord, expStatus());
    rxSegDone = 1;
    @(negedge clk);
    rxSegDone = 0; mSeg = 0;
    check("R8", statusWord, expStatus());

    // random commands with random CRC pulses
    for (int i = 0; i < 400; i++) begin
      logic [31:0] d = $urandom;
      logic p = ($urandom % 4) == 0;
      doCmd("R1 R2 R3 R4 R5 R7 R10", d, p);
    end

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule